// File: doc/BRIEF.md
# Dual-Commit Reorder Buffer

This block keeps the program order of in-flight instructions in an out-of-order core. Rename writes up to two new entries per cycle at the tail, each carrying the instruction's PC, a type code, its architectural destination, the newly allocated physical register and the physical register it replaces. Execution writeback ports mark entries as done by index and may attach an exception code or a branch-mispredict flag.

Retirement happens from the head, at most two entries per cycle and never out of order. For each normally retired entry the block presents the architectural register and new physical register, which update the committed map. It also presents the displaced physical register so it can be returned to the free list. When the oldest completed entry carries an exception or a mispredict, it retires alone and the block requests a flush. An exception retires nothing. A mispredicted branch retires normally. In both cases every younger entry is thrown away by moving the tail to just past the flagged entry.

Top module: `rob_dual`

## Requirements
- R1: After a synchronous active-low reset the buffer is empty, `alloc_ready` is 1, `alloc_idx[0]` is 0, and neither commit lane nor the flush request is active.
- R2: When `alloc_ready` is 1, lane 0 is written at the tail index shown on `alloc_idx[0]` and lane 1 at the next index (`alloc_idx[1]`), and the tail advances by the number of lanes taken. Lane 1 is taken only together with lane 0. `alloc_ready` is 1 exactly when at least two slots are free. A request made while it is 0 changes nothing.
- R3: Entries retire strictly in order. Lane 0 needs the head entry to be done, and lane 1 needs lane 0 to retire normally in the same cycle and the next entry to be done. A done entry behind an unfinished head does not retire.
- R4: Each retiring lane `i` drives `cm_valid[i]`=1 with the entry's `cm_has_dst`, `cm_areg`, `cm_pdst` (new physical register) and `cm_pold` (physical register to free).
- R5: A done head entry marked mispredicted retires alone: `cm_valid`=2'b01, `flush_valid`=1, `flush_exc`=0, `flush_pc` = its PC.
- R6: A done head entry carrying an exception does not retire: `cm_valid`=2'b00, `flush_valid`=1, `flush_exc`=1, with its PC on `flush_pc` and its code on `flush_code`.
- R7: A flagged entry in the second slot does not retire beside the head. It is handled by R5 or R6 on a later cycle, once it has become the head.
- R8: After a flush cycle the buffer is empty and the tail index is one past the flagged entry. Allocation requested in the flush cycle is dropped.
- R9: A wrap bit on each pointer lets the buffer hold all `ENTRIES` entries. When completely full it reports `empty`=0 and `alloc_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 2 | Allocation request per lane |
| alloc_pc | input | 2×PC_W | PC per lane |
| alloc_itype | input | 2×TYPE_W | Instruction type per lane |
| alloc_has_dst | input | 2 | Lane writes a destination register |
| alloc_areg | input | 2×AREG_W | Architectural destination |
| alloc_pdst | input | 2×PREG_W | Newly allocated physical register |
| alloc_pold | input | 2×PREG_W | Physical register previously mapped |
| alloc_ready | output | 1 | At least two free slots |
| alloc_idx | output | 2×IDX_W | Index given to each lane |
| empty | output | 1 | No entries held |
| wb_valid | input | WB_PORTS | Writeback strobe per port |
| wb_idx | input | WB_PORTS×IDX_W | Entry completed |
| wb_exc | input | WB_PORTS | Completion raised an exception |
| wb_exc_code | input | WB_PORTS×EXC_W | Exception code |
| wb_misp | input | WB_PORTS | Branch was mispredicted |
| cm_valid | output | 2 | Lane retires this cycle |
| cm_has_dst | output | 2 | Retiring lane has a destination |
| cm_areg | output | 2×AREG_W | Committed map update: register |
| cm_pdst | output | 2×PREG_W | Committed map update: physical register |
| cm_pold | output | 2×PREG_W | Physical register to free |
| flush_valid | output | 1 | Flush request |
| flush_exc | output | 1 | 1 = exception, 0 = mispredict |
| flush_code | output | EXC_W | Exception code of flagged entry |
| flush_pc | output | PC_W | PC of flagged entry |
| flush_itype | output | TYPE_W | Type of flagged entry |

## Verification
On every cycle the assertions check several structural rules. Lane 1 never retires without lane 0. An exception flush retires nothing, and a mispredict flush retires exactly lane 0. The occupancy never exceeds the depth. Every flush leaves the buffer empty. The tail cannot move while allocation is refused. Only the bench's scenarios can show that the right entries retire with the right register fields. They also show that out-of-order completion is held back, that a flagged second entry waits for the head, and that the tail lands one past the flagged entry. Finally, they show that a completely full buffer is told apart from an empty one.

// File: rtl/rob_pkg.sv
// Package: shared decision record for the reorder buffer.
// Assumes: two commit lanes, fixed by the block's retire width.
package rob_pkg;
    localparam int unsigned LANES = 2;

    typedef struct packed {
        logic go0;        // head entry retires normally
        logic go1;        // second entry retires normally
        logic flush;      // flagged head entry triggers flush
        logic flush_exc;  // 1: exception, 0: mispredict
    } cm_dec_t;
endpackage

// File: rtl/rob_ptr_ctrl.sv
// Module: head/tail pointers with wrap bit for the reorder buffer.
// Assumes: ENTRIES is a power of two, alloc_n is nonzero only while ready,
// commit_n never exceeds occupancy.
module rob_ptr_ctrl #(
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IDX_W = $clog2(ENTRIES),
    localparam int unsigned PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       alloc_n,
    input  logic [1:0]       commit_n,
    input  logic             flush,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic             empty,
    output logic             ready
);
    logic [PTR_W-1:0] head_q, tail_q;
    logic [PTR_W-1:0] used;
    logic [PTR_W:0]   free_cnt;

    // Occupancy and free-slot count from the wrap-extended pointers.
    always_comb begin
        used     = tail_q - head_q;
        free_cnt = (PTR_W+1)'(ENTRIES) - {1'b0, used};
        ready    = free_cnt >= (PTR_W+1)'(2);
        empty    = (used == '0);
        head_idx = head_q[IDX_W-1:0];
        tail_idx = tail_q[IDX_W-1:0];
    end

    // Pointer update: flush collapses to one past head, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else if (flush) begin
            head_q <= head_q + PTR_W'(1);
            tail_q <= head_q + PTR_W'(1);
        end else begin
            head_q <= head_q + PTR_W'(commit_n);
            tail_q <= tail_q + PTR_W'(alloc_n);
        end
    end

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        used <= PTR_W'(ENTRIES));

    a_r2_refused_tail_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !flush) |=> $stable(tail_q));
endmodule

// File: rtl/rob_commit_sel.sv
// Module: picks which of the two oldest entries retire this cycle.
// Assumes: e1 is the entry directly after the head.
module rob_commit_sel
    import rob_pkg::*;
(
    input  logic    e0_valid,
    input  logic    e0_done,
    input  logic    e0_exc,
    input  logic    e0_misp,
    input  logic    e1_valid,
    input  logic    e1_done,
    input  logic    e1_exc,
    input  logic    e1_misp,
    output cm_dec_t dec
);
    logic h0_ready, h1_clean;

    // In-order selection; a flagged entry only acts from the head.
    always_comb begin
        h0_ready = e0_valid && e0_done;
        h1_clean = e1_valid && e1_done && !e1_exc && !e1_misp;
        dec      = '0;
        if (h0_ready) begin
            if (e0_exc) begin
                dec.flush     = 1'b1;
                dec.flush_exc = 1'b1;
            end else if (e0_misp) begin
                dec.go0   = 1'b1;
                dec.flush = 1'b1;
            end else begin
                dec.go0 = 1'b1;
                dec.go1 = h1_clean;
            end
        end
    end
endmodule

// File: rtl/rob_dual.sv
// Module: dual-allocate, dual-commit circular reorder buffer.
// Assumes: rename never asserts alloc lane 1 without lane 0; writeback
// indices refer to live entries (stale ones are ignored via valid bit).
module rob_dual
    import rob_pkg::*;
#(
    parameter int unsigned ENTRIES  = 64,
    parameter int unsigned PC_W     = 64,
    parameter int unsigned TYPE_W   = 3,
    parameter int unsigned AREG_W   = 5,
    parameter int unsigned PREG_W   = 6,
    parameter int unsigned EXC_W    = 5,
    parameter int unsigned WB_PORTS = 2,
    localparam int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [1:0]                       alloc_valid,
    input  logic [1:0][PC_W-1:0]             alloc_pc,
    input  logic [1:0][TYPE_W-1:0]           alloc_itype,
    input  logic [1:0]                       alloc_has_dst,
    input  logic [1:0][AREG_W-1:0]           alloc_areg,
    input  logic [1:0][PREG_W-1:0]           alloc_pdst,
    input  logic [1:0][PREG_W-1:0]           alloc_pold,
    output logic                             alloc_ready,
    output logic [1:0][IDX_W-1:0]            alloc_idx,
    output logic                             empty,
    input  logic [WB_PORTS-1:0]              wb_valid,
    input  logic [WB_PORTS-1:0][IDX_W-1:0]   wb_idx,
    input  logic [WB_PORTS-1:0]              wb_exc,
    input  logic [WB_PORTS-1:0][EXC_W-1:0]   wb_exc_code,
    input  logic [WB_PORTS-1:0]              wb_misp,
    output logic [1:0]                       cm_valid,
    output logic [1:0]                       cm_has_dst,
    output logic [1:0][AREG_W-1:0]           cm_areg,
    output logic [1:0][PREG_W-1:0]           cm_pdst,
    output logic [1:0][PREG_W-1:0]           cm_pold,
    output logic                             flush_valid,
    output logic                             flush_exc,
    output logic [EXC_W-1:0]                 flush_code,
    output logic [PC_W-1:0]                  flush_pc,
    output logic [TYPE_W-1:0]                flush_itype
);
    typedef struct packed {
        logic              done;
        logic              exc;
        logic [EXC_W-1:0]  code;
        logic              misp;
        logic [PC_W-1:0]   pc;
        logic [TYPE_W-1:0] itype;
        logic              has_dst;
        logic [AREG_W-1:0] areg;
        logic [PREG_W-1:0] pdst;
        logic [PREG_W-1:0] pold;
    } ent_t;

    ent_t             ent   [ENTRIES];
    logic [ENTRIES-1:0] vld;
    logic [IDX_W-1:0] head_idx, tail_idx, head_nx;
    logic [1:0]       take, alloc_n, commit_n;
    cm_dec_t          dec;
    ent_t             e0, e1;

    rob_ptr_ctrl #(.ENTRIES(ENTRIES)) u_ptr (
        .clk(clk), .rst_n(rst_n), .alloc_n(alloc_n), .commit_n(commit_n),
        .flush(dec.flush), .head_idx(head_idx), .tail_idx(tail_idx),
        .empty(empty), .ready(alloc_ready)
    );

    rob_commit_sel u_sel (
        .e0_valid(vld[head_idx]), .e0_done(e0.done), .e0_exc(e0.exc), .e0_misp(e0.misp),
        .e1_valid(vld[head_nx]),  .e1_done(e1.done), .e1_exc(e1.exc), .e1_misp(e1.misp),
        .dec(dec)
    );

    // Allocation gating, lane indices and head-entry views.
    always_comb begin
        head_nx      = head_idx + IDX_W'(1);
        e0           = ent[head_idx];
        e1           = ent[head_nx];
        alloc_idx[0] = tail_idx;
        alloc_idx[1] = tail_idx + IDX_W'(1);
        take[0]      = alloc_ready && !dec.flush && alloc_valid[0];
        take[1]      = take[0] && alloc_valid[1];
        alloc_n      = 2'(take[0]) + 2'(take[1]);
        commit_n     = 2'(dec.go0) + 2'(dec.go1);
    end

    // Commit and flush outputs driven from the two oldest entries.
    always_comb begin
        cm_valid    = {dec.go1, dec.go0};
        cm_has_dst  = {e1.has_dst, e0.has_dst};
        cm_areg     = {e1.areg, e0.areg};
        cm_pdst     = {e1.pdst, e0.pdst};
        cm_pold     = {e1.pold, e0.pold};
        flush_valid = dec.flush;
        flush_exc   = dec.flush_exc;
        flush_code  = e0.code;
        flush_pc    = e0.pc;
        flush_itype = e0.itype;
    end

    // Valid bits: cleared by reset, flush or retirement; set by allocation.
    always_ff @(posedge clk) begin
        if (!rst_n || dec.flush) begin
            vld <= '0;
        end else begin
            if (dec.go0) vld[head_idx] <= 1'b0;
            if (dec.go1) vld[head_nx]  <= 1'b0;
            if (take[0]) vld[alloc_idx[0]] <= 1'b1;
            if (take[1]) vld[alloc_idx[1]] <= 1'b1;
        end
    end

    // Entry payload: writeback marks completion, allocation loads fields.
    always_ff @(posedge clk) begin
        for (int p = 0; p < WB_PORTS; p++) begin
            if (wb_valid[p] && vld[wb_idx[p]]) begin
                ent[wb_idx[p]].done <= 1'b1;
                ent[wb_idx[p]].exc  <= wb_exc[p];
                ent[wb_idx[p]].code <= wb_exc_code[p];
                ent[wb_idx[p]].misp <= wb_misp[p];
            end
        end
        for (int l = 0; l < LANES; l++) begin
            if (take[l]) begin
                ent[alloc_idx[l]] <= '{done: 1'b0, exc: 1'b0, code: '0, misp: 1'b0,
                                       pc: alloc_pc[l], itype: alloc_itype[l],
                                       has_dst: alloc_has_dst[l], areg: alloc_areg[l],
                                       pdst: alloc_pdst[l], pold: alloc_pold[l]};
            end
        end
    end

    a_r3_lane1_needs_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid[1] |-> cm_valid[0]);

    a_r6_exc_retires_none: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && flush_exc) |-> (cm_valid == 2'b00));

    a_r5_misp_retires_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && !flush_exc) |-> (cm_valid == 2'b01));

    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> empty);
endmodule

// File: tb/sim_rob_dual.sv
// Bench: table of two-entry scenarios plus directed fill/order/flush tests.
module sim_rob_dual;
    localparam int ENTRIES = 64;
    localparam int IDX_W   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] alloc_valid = '0;
    logic [1:0][63:0] alloc_pc = '0;
    logic [1:0][2:0] alloc_itype = '0;
    logic [1:0] alloc_has_dst = '0;
    logic [1:0][4:0] alloc_areg = '0;
    logic [1:0][5:0] alloc_pdst = '0;
    logic [1:0][5:0] alloc_pold = '0;
    logic alloc_ready, empty;
    logic [1:0][IDX_W-1:0] alloc_idx;
    logic [1:0] wb_valid = '0;
    logic [1:0][IDX_W-1:0] wb_idx = '0;
    logic [1:0] wb_exc = '0;
    logic [1:0][4:0] wb_exc_code = '0;
    logic [1:0] wb_misp = '0;
    logic [1:0] cm_valid, cm_has_dst;
    logic [1:0][4:0] cm_areg;
    logic [1:0][5:0] cm_pdst, cm_pold;
    logic flush_valid, flush_exc;
    logic [4:0] flush_code;
    logic [63:0] flush_pc;
    logic [2:0] flush_itype;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [IDX_W-1:0] exp_tail = '0;

    always #5 clk = ~clk;

    rob_dual u0 (.*);

    // Scenario table: {flag of entry 1, flag of entry 0}; 0 normal, 1 mispredict, 2 exception.
    localparam logic [3:0] VEC [8] = '{4'h0, 4'h1, 4'h4, 4'h2, 4'h8, 4'hA, 4'h9, 4'h0};

    function automatic logic [5:0] pold_of(input logic [IDX_W-1:0] i);
        return 6'(i) ^ 6'h2A;
    endfunction
    function automatic logic [63:0] pc_of(input logic [IDX_W-1:0] i);
        return 64'h8000_0000 + 64'(i) * 4;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_alloc(input logic [1:0] v);
        alloc_valid = v;
        for (int l = 0; l < 2; l++) begin
            logic [IDX_W-1:0] ix;
            ix = alloc_idx[0] + IDX_W'(l);
            alloc_pc[l] = pc_of(ix);
            alloc_itype[l] = 3'(l + 1);
            alloc_has_dst[l] = 1'b1;
            alloc_areg[l] = 5'(ix);
            alloc_pdst[l] = 6'(ix);
            alloc_pold[l] = pold_of(ix);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        alloc_valid = '0;
        wb_valid = '0;
        wb_exc = '0;
        wb_misp = '0;
        #1;
    endtask

    task automatic wb(input int port, input logic [IDX_W-1:0] ix, input logic [1:0] flag);
        wb_valid[port] = 1'b1;
        wb_idx[port] = ix;
        wb_exc[port] = (flag == 2'd2);
        wb_misp[port] = (flag == 2'd1);
        wb_exc_code[port] = 5'(ix) + 5'd3;
    endtask

    // Expected outcome of the head cycle for a flagged or clean entry.
    task automatic expect_flag(input logic [1:0] f, input logic [IDX_W-1:0] ix, input logic [1:0] cm_exp);
        chk(cm_valid == cm_exp, f == 2 ? "R6 exc commit lanes" : "R5 misp commit lanes", 64'(cm_valid), 64'(cm_exp));
        chk(flush_valid && (flush_exc == (f == 2)), f == 2 ? "R6 exc flush" : "R5 misp flush",
            {flush_valid, flush_exc}, {1'b1, f == 2});
        chk(flush_pc == pc_of(ix), "R5/R6 flush pc", flush_pc, pc_of(ix));
        if (f == 2) chk(flush_code == 5'(ix) + 5'd3, "R6 flush code", 64'(flush_code), 64'(5'(ix) + 5'd3));
    endtask

    task automatic run_pair(input logic [3:0] v);
        logic [1:0] f0, f1;
        logic [IDX_W-1:0] t;
        f0 = v[1:0];
        f1 = v[3:2];
        t = exp_tail;
        chk(alloc_idx[0] == t && alloc_ready, "R2 alloc index", 64'(alloc_idx[0]), 64'(t));
        drive_alloc(2'b11);
        step();
        wb(0, t, f0);
        wb(1, t + IDX_W'(1), f1);
        step();
        if (f0 != 0) begin
            expect_flag(f0, t, f0 == 2 ? 2'b00 : 2'b01);
            exp_tail = t + IDX_W'(1);
        end else if (f1 == 0) begin
            chk(cm_valid == 2'b11 && !flush_valid, "R3 dual retire", {flush_valid, cm_valid}, 64'h3);
            chk(cm_pold[0] == pold_of(t) && cm_pold[1] == pold_of(t + IDX_W'(1)), "R4 free regs",
                {cm_pold[1], cm_pold[0]}, {pold_of(t + IDX_W'(1)), pold_of(t)});
            chk(cm_pdst[1] == 6'(t + IDX_W'(1)) && cm_areg[0] == 5'(t) && cm_has_dst == 2'b11,
                "R4 map update", 64'(cm_pdst[1]), 64'(t + IDX_W'(1)));
            exp_tail = t + IDX_W'(2);
        end else begin
            chk(cm_valid == 2'b01 && !flush_valid, "R7 flagged second waits", {flush_valid, cm_valid}, 64'h1);
            step();
            expect_flag(f1, t + IDX_W'(1), f1 == 2 ? 2'b00 : 2'b01);
            exp_tail = t + IDX_W'(2);
        end
        step();
        chk(empty && alloc_idx[0] == exp_tail, "R8 empty after scenario", {empty, alloc_idx[0]}, {1'b1, exp_tail});
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected<=100000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin : main
        logic [IDX_W-1:0] s;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(empty && alloc_ready, "R1 empty and ready", {empty, alloc_ready}, 2'b11);
        chk(alloc_idx[0] == 0 && cm_valid == 0 && !flush_valid, "R1 idle outputs",
            {alloc_idx[0], cm_valid, flush_valid}, 0);

        foreach (VEC[k]) run_pair(VEC[k]);

        // R9/R2 fill to capacity without completion
        s = exp_tail;
        for (int p = 0; p < ENTRIES / 2; p++) begin
            if (p == ENTRIES / 2 - 1)
                chk(alloc_ready, "R2 ready with two free", 64'(alloc_ready), 1);
            drive_alloc(2'b11);
            step();
        end
        chk(!alloc_ready && !empty && alloc_idx[0] == s, "R9 full not empty",
            {alloc_ready, empty, alloc_idx[0]}, {2'b00, s});
        drive_alloc(2'b11);
        step();
        chk(alloc_idx[0] == s && !empty, "R2 refused request ignored", 64'(alloc_idx[0]), 64'(s));

        // R3 out-of-order completion is held back
        wb(0, s + IDX_W'(1), 2'd0);
        step();
        chk(cm_valid == 2'b00, "R3 unfinished head blocks", 64'(cm_valid), 0);
        wb(1, s, 2'd0);
        step();
        chk(cm_valid == 2'b11 && cm_pold[0] == pold_of(s), "R3 R4 in-order retire",
            {cm_valid, cm_pold[0]}, {2'b11, pold_of(s)});
        step();
        chk(alloc_ready && cm_valid == 2'b00, "R2 ready after retire", {alloc_ready, cm_valid}, 2'b10);

        // R8 flush drops same-cycle allocation
        wb(0, s + IDX_W'(2), 2'd2);
        step();
        chk(flush_valid && flush_exc, "R6 exception at head", {flush_valid, flush_exc}, 2'b11);
        drive_alloc(2'b11);
        step();
        chk(empty && alloc_idx[0] == s + IDX_W'(3), "R8 flush drops alloc",
            {empty, alloc_idx[0]}, {1'b1, s + IDX_W'(3)});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule